// File: doc/BRIEF.md
# External Interrupt Detector with Noise Filter

This block watches four external interrupt pins and turns their activity into pending requests for a processor core. Every pin passes through a two-stage synchroniser. The two low-numbered pins can trigger on a rising edge, a falling edge, a high level or a low level. The two high-numbered pins trigger on a rising edge, a falling edge or either edge. Pin 2 must hold a new level for two cycles before it is accepted. Pin 3 goes through a sampling filter whose sample rate is the cycle clock divided by 1, 16 or 64, and it accepts a new level only when two consecutive samples agree.

Each pin has a pending flag and an enable bit. The block presents the vector of the highest-priority pending request that is enabled. Qualified edges on pins 2 and 3 also produce a one-cycle event pulse that a timer can count. Pins 0 and 1 drive a wake request that releases a stop mode. An edge-triggered flag stays set until software writes a 1 to that pin's clear bit. A level-triggered request follows the synchronised pin.

Top module: `ext_irq_detector`

## Requirements
- R1: For pins 0 and 1, mode field `trig_mode[2i+1:2i]` encodes 00 = rising edge, 01 = falling edge, 10 = high level and 11 = low level. In an edge mode, only the selected edge direction sets `pend[i]`.
- R2: An edge-set pending flag stays at 1 until a cycle with `int_clr[i]` = 1 clears it. When an edge and a clear arrive in the same cycle, the edge wins.
- R3: In a level mode, `pend[i]` follows the synchronised pin: 1 while the pin is at the active level and 0 otherwise. `int_clr` has no effect in this mode.
- R4: For pins 2 and 3, mode 00 = rising edge, 01 = falling edge, and 10 or 11 = both edges.
- R5: `irq_req` is 1 when any `pend & irq_en` bit is set. `irq_vec` is then 8'h03, 8'h0B, 8'h13 or 8'h1B for pin 0, 1, 2 or 3. When no request is enabled, `irq_req` = 0 and `irq_vec` = 8'h00.
- R6: Priority is fixed, from highest to lowest: pin 0, pin 1, pin 2, pin 3. `irq_en` gates `irq_req`, `irq_vec` and `wake_req`, but never `pend`.
- R7: A pulse on pin 2 that lasts one cycle is ignored. A pulse of two cycles or more is accepted.
- R8: The pin 3 filter samples every 1, 16 or 64 cycles when `flt_sel` is 00, 01 or 1x. A pulse shorter than one sample period is ignored. A pulse of at least two sample periods is accepted.
- R9: `tmr_evt` pulses high for exactly one cycle for each qualified trigger edge on pin 2 or pin 3.
- R10: `wake_req` is 1 while pin 0 or pin 1 is pending and enabled.
- R11: After reset, `pend`, `irq_req`, `irq_vec`, `tmr_evt` and `wake_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cycle clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| int_pin | input | 4 | Asynchronous external interrupt pins |
| trig_mode | input | 8 | Two-bit trigger mode per pin; pin i uses bits [2i+1:2i] |
| irq_en | input | 4 | Enable for each pin's request |
| int_clr | input | 4 | Write-1 pulse that clears an edge pending flag |
| flt_sel | input | 2 | Pin 3 filter rate: 00 = /1, 01 = /16, 1x = /64 |
| pend | output | 4 | Pending flag for each pin |
| irq_req | output | 1 | At least one request is pending and enabled |
| irq_vec | output | 8 | Vector of the winning request |
| tmr_evt | output | 1 | One-cycle event pulse for pins 2 and 3 |
| wake_req | output | 1 | Stop-mode release request from pins 0 and 1 |

## Verification
Random masks of rising pulses on all four pins, paired with random enable masks, check the pending flags, the priority pick and the wake request against a bench model. These patterns separate an encoder with the wrong priority from one whose enable gating is misplaced. Directed edges of the wrong direction, and level toggles, separate edge capture from level following and show that a flag is sticky until cleared. Pulses just below and well above the minimum width, at each filter rate, show that the filter rejects glitches without losing real events. Counting `tmr_evt` pulses over both-edge toggles shows that each qualified edge gives exactly one timer event.

// File: rtl/eid_pkg.sv
package eid_pkg;
  localparam int NPIN = 4;

  // edge detect; lvl_ok selects the pin-0/1 encoding (1x = level)
  function automatic logic edge_hit(input logic [1:0] m, input logic lvl_ok,
                                    input logic prev, input logic cur);
    logic rise, fall;
    rise = cur & ~prev;
    fall = prev & ~cur;
    if (lvl_ok)
      return (m == 2'b00) ? rise : (m == 2'b01) ? fall : 1'b0;
    else
      return (m == 2'b00) ? rise : (m == 2'b01) ? fall : (rise | fall);
  endfunction

  function automatic logic lvl_active(input logic [1:0] m, input logic cur);
    return (m == 2'b10) ? cur : (m == 2'b11) ? ~cur : 1'b0;
  endfunction

  function automatic logic [7:0] vec_of(input logic [1:0] idx);
    return {3'b000, idx, 3'b011};
  endfunction
endpackage

// File: rtl/eid_sync.sv
module eid_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/eid_ticker.sv
module eid_ticker #(
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam int CW = $clog2(DIV_HI) + 1;
  logic [CW-1:0] cnt, lim;

  always_comb begin
    case (sel)
      2'b00:   lim = '0;
      2'b01:   lim = CW'(DIV_MID - 1);
      default: lim = CW'(DIV_HI - 1);
    endcase
  end

  assign tick = (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/eid_filter.sv
module eid_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic din,
  output logic dout
);
  logic smp;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp  <= 1'b0;
      dout <= 1'b0;
    end else if (tick) begin
      smp <= din;
      if (din == smp) dout <= din;
    end
  end
endmodule

// File: rtl/eid_pin.sv
module eid_pin
  import eid_pkg::*;
#(
  parameter bit LEVEL_OK = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  input  logic [1:0] mode,
  input  logic       clr,
  output logic       pend,
  output logic       hit
);
  logic prev, flag, lvl_mode;

  assign lvl_mode = LEVEL_OK && mode[1];
  assign hit      = edge_hit(mode, LEVEL_OK, prev, lvl);
  assign pend     = lvl_mode ? lvl_active(mode, lvl) : flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b0;
      flag <= 1'b0;
    end else begin
      prev <= lvl;
      if (lvl_mode) flag <= 1'b0;
      else if (hit) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/eid_prio.sv
module eid_prio
  import eid_pkg::*;
(
  input  logic [NPIN-1:0] act,
  output logic            req,
  output logic [7:0]      vec
);
  always_comb begin
    req = 1'b0;
    vec = 8'h00;
    for (int i = NPIN - 1; i >= 0; i--) begin
      if (act[i]) begin
        req = 1'b1;
        vec = vec_of(2'(i));
      end
    end
  end
endmodule

// File: rtl/ext_irq_detector.sv
module ext_irq_detector
  import eid_pkg::*;
#(
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] int_pin,
  input  logic [7:0] trig_mode,
  input  logic [3:0] irq_en,
  input  logic [3:0] int_clr,
  input  logic [1:0] flt_sel,
  output logic [3:0] pend,
  output logic       irq_req,
  output logic [7:0] irq_vec,
  output logic       tmr_evt,
  output logic       wake_req
);
  logic [NPIN-1:0] pin_s;
  logic [NPIN-1:0] lvl_q;
  logic [NPIN-1:0] hit_w;
  logic            flt_tick;

  eid_sync #(.W(NPIN)) u_sync (.clk(clk), .rst_n(rst_n), .d(int_pin), .q(pin_s));

  eid_ticker #(.DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_tick (
    .clk(clk), .rst_n(rst_n), .sel(flt_sel), .tick(flt_tick));

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    if (i < 2) begin : g_raw
      assign lvl_q[i] = pin_s[i];
    end else begin : g_flt
      eid_filter u_flt (
        .clk(clk), .rst_n(rst_n),
        .tick((i == 2) ? 1'b1 : flt_tick),
        .din(pin_s[i]), .dout(lvl_q[i]));
    end
    eid_pin #(.LEVEL_OK(i < 2)) u_pin (
      .clk(clk), .rst_n(rst_n), .lvl(lvl_q[i]),
      .mode(trig_mode[2*i+1:2*i]), .clr(int_clr[i]),
      .pend(pend[i]), .hit(hit_w[i]));
  end

  eid_prio u_prio (.act(pend & irq_en), .req(irq_req), .vec(irq_vec));

  assign tmr_evt  = hit_w[2] | hit_w[3];
  assign wake_req = |(pend[1:0] & irq_en[1:0]);
endmodule

// File: rtl/eid_checker.sv
module eid_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] trig_mode,
  input logic [3:0] irq_en,
  input logic [3:0] int_clr,
  input logic [3:0] pend,
  input logic       irq_req,
  input logic [7:0] irq_vec,
  input logic       tmr_evt,
  input logic       wake_req
);
  a_r5_vec_form: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec[2:0] == 3'b011 && irq_vec[7:5] == 3'b000));
  a_r5_idle_vec: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> irq_vec == 8'h00);
  a_r6_top_prio: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[0] && irq_en[0]) |-> irq_vec == 8'h03);
  a_r2_hold_p0: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[0] && !trig_mode[1] && !int_clr[0]) |=> (trig_mode[1] || pend[0]));
  a_r2_hold_p2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[2] && !int_clr[2]) |=> pend[2]);
  a_r2_hold_p3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[3] && !int_clr[3]) |=> pend[3]);
  a_r9_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_evt |=> (pend[3:2] != 2'b00));
  a_r10_wake_req: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> irq_req);
endmodule

bind ext_irq_detector eid_checker u_chk (
  .clk(clk), .rst_n(rst_n), .trig_mode(trig_mode), .irq_en(irq_en),
  .int_clr(int_clr), .pend(pend), .irq_req(irq_req), .irq_vec(irq_vec),
  .tmr_evt(tmr_evt), .wake_req(wake_req));

// File: tb/ext_irq_detector_test.sv
module ext_irq_detector_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] int_pin = '0;
  logic [7:0] trig_mode = '0;
  logic [3:0] irq_en = '0;
  logic [3:0] int_clr = '0;
  logic [1:0] flt_sel = '0;
  logic [3:0] pend;
  logic       irq_req, tmr_evt, wake_req;
  logic [7:0] irq_vec;

  int checks = 0;
  int fails = 0;
  int evt_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_detector uut (
    .clk(clk), .rst_n(rst_n), .int_pin(int_pin), .trig_mode(trig_mode),
    .irq_en(irq_en), .int_clr(int_clr), .flt_sel(flt_sel), .pend(pend),
    .irq_req(irq_req), .irq_vec(irq_vec), .tmr_evt(tmr_evt), .wake_req(wake_req));

  always @(negedge clk) if (tmr_evt) evt_cnt++;

  function automatic logic [7:0] exp_vec(input logic [3:0] m);
    if (m[0]) return 8'h03;
    if (m[1]) return 8'h0B;
    if (m[2]) return 8'h13;
    if (m[3]) return 8'h1B;
    return 8'h00;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_all;
    int_clr = 4'hF; cyc(1); int_clr = 4'h0; cyc(1);
  endtask

  task automatic pulse3(input int w);
    int_pin[3] = 1'b1; cyc(w); int_pin[3] = 1'b0; cyc(200);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    cyc(3);
    // R11 reset state
    check("R11 pend", pend, 0);
    check("R11 req", irq_req, 0);
    check("R11 vec", irq_vec, 0);
    check("R11 evt", tmr_evt, 0);
    check("R11 wake", wake_req, 0);
    rst_n = 1'b1; cyc(3);

    // R1 rising edge on pin 0, R2 sticky until clear
    trig_mode = 8'h00;
    int_pin[0] = 1; cyc(5);
    check("R1 rise sets", pend[0], 1);
    cyc(10);
    check("R2 sticky", pend[0], 1);
    int_clr[0] = 1; cyc(1); int_clr[0] = 0; cyc(1);
    check("R2 cleared", pend[0], 0);
    int_pin[0] = 0; cyc(5);
    check("R1 fall ignored in rise mode", pend[0], 0);
    // R1 falling mode on pin 1
    trig_mode[3:2] = 2'b01;
    int_pin[1] = 1; cyc(5);
    check("R1 rise ignored in fall mode", pend[1], 0);
    int_pin[1] = 0; cyc(5);
    check("R1 fall sets", pend[1], 1);
    // R2 edge wins over clear in the same cycle (hit occurs 2 edges after driving)
    clear_all;
    trig_mode[3:2] = 2'b00;
    int_pin[1] = 1; cyc(2); int_clr[1] = 1; cyc(1); int_clr[1] = 0; cyc(1);
    check("R2 edge beats clear", pend[1], 1);
    int_pin[1] = 0; clear_all;

    // R3 level modes on pin 0
    trig_mode[1:0] = 2'b10;
    int_pin[0] = 1; cyc(3);
    check("R3 high level active", pend[0], 1);
    int_clr[0] = 1; cyc(1); int_clr[0] = 0;
    check("R3 clear no effect", pend[0], 1);
    // R10 / R6 wake gated by enable
    irq_en = 4'b0001; cyc(1);
    check("R10 wake on", wake_req, 1);
    irq_en = 4'b0000; cyc(1);
    check("R10 wake off when disabled", wake_req, 0);
    check("R6 pend kept when disabled", pend[0], 1);
    int_pin[0] = 0; cyc(3);
    check("R3 high level inactive", pend[0], 0);
    trig_mode[1:0] = 2'b11; cyc(1);
    check("R3 low level active", pend[0], 1);
    trig_mode[1:0] = 2'b00; cyc(1); clear_all;

    // R4 both edges on pin 2, R9 event count
    trig_mode[5:4] = 2'b10; evt_cnt = 0;
    int_pin[2] = 1; cyc(8);
    check("R4 both rise", pend[2], 1);
    clear_all;
    int_pin[2] = 0; cyc(8);
    check("R4 both fall", pend[2], 1);
    check("R9 two events", evt_cnt, 2);
    clear_all;
    trig_mode[5:4] = 2'b01;
    int_pin[2] = 1; cyc(8);
    check("R4 fall mode ignores rise", pend[2], 0);
    int_pin[2] = 0; cyc(8);
    check("R4 fall mode sets", pend[2], 1);
    clear_all; trig_mode[5:4] = 2'b00;

    // R7 pin 2 width
    int_pin[2] = 1; cyc(1); int_pin[2] = 0; cyc(8);
    check("R7 one-cycle rejected", pend[2], 0);
    int_pin[2] = 1; cyc(2); int_pin[2] = 0; cyc(8);
    check("R7 two-cycle accepted", pend[2], 1);
    clear_all;

    // R8 pin 3 filter at each rate
    trig_mode[7:6] = 2'b00; evt_cnt = 0;
    flt_sel = 2'b00;
    pulse3(1); check("R8 div1 short", pend[3], 0);
    pulse3(2); check("R8 div1 long", pend[3], 1); clear_all;
    flt_sel = 2'b01;
    pulse3(12); check("R8 div16 short", pend[3], 0);
    pulse3(40); check("R8 div16 long", pend[3], 1); clear_all;
    flt_sel = 2'b10;
    pulse3(50); check("R8 div64 short", pend[3], 0);
    pulse3(140); check("R8 div64 long", pend[3], 1); clear_all;
    check("R9 event count pin3", evt_cnt, 3);
    flt_sel = 2'b00;

    // R5 / R6 priority walk
    trig_mode = 8'h00;
    int_pin = 4'hF; cyc(8); int_pin = 4'h0; cyc(8);
    irq_en = 4'hF; cyc(1);
    check("R5 vec pin0", irq_vec, 8'h03);
    int_clr = 4'b0001; cyc(1); int_clr = 0; cyc(1);
    check("R6 vec pin1", irq_vec, 8'h0B);
    int_clr = 4'b0010; cyc(1); int_clr = 0; cyc(1);
    check("R6 vec pin2", irq_vec, 8'h13);
    int_clr = 4'b0100; cyc(1); int_clr = 0; cyc(1);
    check("R5 vec pin3", irq_vec, 8'h1B);
    irq_en = 4'h0; cyc(1);
    check("R5 no req", irq_req, 0);
    check("R5 idle vec", irq_vec, 8'h00);
    clear_all;

    // random masks, R5 R6 R10
    for (int it = 0; it < 24; it++) begin
      logic [3:0] p, e;
      p = 4'($urandom);
      e = 4'($urandom);
      irq_en = e;
      int_pin = p; cyc(8);
      check("R6 rand pend", pend, p);
      check("R5 rand vec", irq_vec, exp_vec(p & e));
      check("R5 rand req", irq_req, |(p & e));
      check("R10 rand wake", wake_req, |(p[1:0] & e[1:0]));
      int_pin = 0; cyc(8); clear_all;
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule